// File: doc/BRIEF.md
# Page Access Check and Fault Status Unit

This block sits beside a page-table walker. Once a page entry has been fetched, the walker presents the request kind (load, store, instruction fetch or a combined store-and-fetch), the privilege of the requester, the entry's 3-bit permission code and its modified bit. In the same cycle the unit returns a fault code, a fault flag and the read/write/execute rights that may be installed for the page.

Every fault that is not suppressed is recorded. An 8-bit status word holds the access index, the fault type, a valid bit and a sticky overflow bit. An address register holds the page-aligned virtual address of the last fault. When the no-fault mode is on, or traps are disabled, a faulting access is not trapped and is granted full rights. Otherwise a one-cycle trap pulse goes out on either the fetch trap or the data trap output. Software reads the status word through a read strobe that also clears it.

Top module: `acc_check_unit`

## Requirements
- R1: The access index is {write, fetch, supervisor} (bit 2 write, bit 1 fetch, bit 0 supervisor). A valid request faults with code 8 (protection) when it lacks a needed right. A load needs read, a store needs write, a fetch needs execute, and store-and-fetch needs both write and execute. Otherwise the code is 0.
- R2: A user request (supervisor = 0) against permission code 6 or 7 gets code 12 (privilege violation), whatever its kind.
- R3: When the no-fault mode is set, a user request never faults: code 0, fault flag low, status, address and traps untouched.
- R4: Rights on grant_o are bit 0 read, bit 1 write, bit 2 execute. For permission codes 0..7 a user gets R, RW, RX, RWX, X, R, none, none, and a supervisor gets R, RW, RX, RWX, X, RW, RX, RWX.
- R5: When the modified bit is clear, write is removed from the granted rights of a request that does not fault.
- R6: A faulting request made while no-fault mode is set or traps are disabled gets rights 3'b111 and raises no trap. A faulting request made with traps enabled and no-fault mode clear gets rights 0.
- R7: A trapped fault pulses fetch_trap_o (if the request was a fetch) or data_trap_o (otherwise) in the cycle after the request, for one cycle. The two never pulse together.
- R8: A fault written into an empty (zero) status word leaves the status word equal to (access index << 5) | code | 2: bits 7:5 index, bits 3:2 type, bit 1 valid.
- R9: A fault that arrives while the status word is non-zero and not being read discards the old content and leaves (access index << 5) | code | 3, with bit 0 marking overflow.
- R10: On every recorded fault the address register captures the request address with its low PAGE_W bits cleared. Otherwise it holds its value.
- R11: A cycle with fsr_rd_i high presents the current status and clears it to zero for the next cycle. A fault in the same cycle is recorded as a fresh one, without overflow.
- R12: Reset clears the status, address and trap outputs. With req_valid_i low, the fault flag, code and rights are all zero and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | Request writes |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_super_i | input | 1 | Requester is in supervisor mode |
| req_vaddr_i | input | VA_W | Virtual address of the request |
| pte_perm_i | input | 3 | Permission code of the page entry |
| pte_mod_i | input | 1 | Modified bit of the page entry |
| nofault_mode_i | input | 1 | No-fault mode enable |
| trap_en_i | input | 1 | Traps enabled |
| fsr_rd_i | input | 1 | Software read strobe of the status word (clears it) |
| fault_o | output | 1 | Request faults and is recorded |
| fault_code_o | output | 4 | 0, 8 (protection) or 12 (privilege) |
| grant_o | output | 3 | Granted rights {exec, write, read} |
| fetch_trap_o | output | 1 | One-cycle fetch fault trap |
| data_trap_o | output | 1 | One-cycle data fault trap |
| fsr_o | output | 8 | Fault status word |
| far_o | output | VA_W | Fault address register |

## Verification
The bench sweeps every access index against every permission code, with both values of the modified bit, no-fault mode, trap enable and request valid. Each case is compared with a literal fault matrix and the per-privilege rights tables. This catches a swapped index bit or a wrong rights decode, because either one moves an 8 or a 12 into the wrong cell. The status read strobe fires every third cycle, so back-to-back faults with and without an intervening read occur throughout. A design that kept old fields on overflow, flagged overflow after a read, or let a read lose a same-cycle fault would give a wrong status word there. Suppressed user faults and bypassed faults are checked for untouched state, for full rights and for the absence of a trap pulse.

// File: rtl/acc_check_pkg.sv
package acc_check_pkg;
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  typedef logic [3:0] fcode_t;

  localparam fcode_t FC_NONE = 4'd0;
  localparam fcode_t FC_PROT = 4'd8;
  localparam fcode_t FC_PRIV = 4'd12;

  localparam int unsigned AIDX_W   = 3;
  localparam int unsigned AIDX_LSB = 5;
  localparam int unsigned FSR_W    = AIDX_LSB + AIDX_W;
  localparam int unsigned FSR_OVF  = 0;
  localparam int unsigned FSR_VLD  = 1;
endpackage

// File: rtl/acc_rights_dec.sv
module acc_rights_dec
  import acc_check_pkg::*;
(
  input  logic [2:0] perm_i,
  input  logic       super_i,
  output rights_t    rights_o
);
  logic super_only;

  always_comb begin
    super_only  = perm_i[2] & perm_i[1];
    rights_o.r  = (perm_i != 3'd4);
    rights_o.w  = perm_i[0] & (super_i | ~perm_i[2]);
    rights_o.x  = perm_i[1] | (perm_i == 3'd4);
    if (!super_i && super_only) rights_o = '0;
  end
endmodule

// File: rtl/acc_fault_eval.sv
module acc_fault_eval
  import acc_check_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic              super_i,
  input  logic [2:0]        perm_i,
  input  rights_t           rights_i,
  input  logic              dirty_i,
  input  logic              nofault_i,
  input  logic              trap_en_i,
  output logic [AIDX_W-1:0] acc_idx_o,
  output fcode_t            code_o,
  output logic              fault_o,
  output logic              trap_o,
  output rights_t           grant_o
);
  logic [2:0] need, have, miss;
  fcode_t     raw;
  logic       suppress, bypass;

  always_comb begin
    acc_idx_o = {write_i, fetch_i, super_i};
    need      = {fetch_i, write_i, ~write_i & ~fetch_i};
    have      = rights_i;
    miss      = need & ~have;
    if (!super_i && perm_i[2:1] == 2'b11) raw = FC_PRIV;
    else if (|miss)                       raw = FC_PROT;
    else                                  raw = FC_NONE;

    suppress = nofault_i & ~super_i;
    code_o   = (valid_i && !suppress) ? raw : FC_NONE;
    fault_o  = (code_o != FC_NONE);
    bypass   = nofault_i | ~trap_en_i;
    trap_o   = fault_o & ~bypass;

    grant_o = rights_i;
    if (!dirty_i) grant_o.w = 1'b0;  // write only once page is dirty
    if (!valid_i)     grant_o = '0;
    else if (fault_o) grant_o = bypass ? '1 : '0;
  end
endmodule

// File: rtl/acc_fault_log.sv
module acc_fault_log
  import acc_check_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              trap_i,
  input  logic              fetch_i,
  input  logic [AIDX_W-1:0] acc_idx_i,
  input  fcode_t            code_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              rd_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [VA_W-1:0]   far_o,
  output logic              fetch_trap_o,
  output logic              data_trap_o
);
  localparam logic [VA_W-1:0] PAGE_MASK = {{(VA_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [FSR_W-1:0] fsr_q, fsr_base, fsr_d;
  logic [VA_W-1:0]  far_q;
  logic             ftrap_q, dtrap_q;

  always_comb begin
    fsr_base = rd_i ? '0 : fsr_q;  // a read acknowledges before a new fault lands
    fsr_d    = fsr_base;
    if (fault_i) begin
      fsr_d                           = '0;
      fsr_d[FSR_OVF]                  = |fsr_base;
      fsr_d[FSR_VLD]                  = 1'b1;
      fsr_d[AIDX_LSB +: AIDX_W]       = acc_idx_i;
      fsr_d                           = fsr_d | FSR_W'(code_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q   <= '0;
      far_q   <= '0;
      ftrap_q <= 1'b0;
      dtrap_q <= 1'b0;
    end else begin
      fsr_q   <= fsr_d;
      if (fault_i) far_q <= vaddr_i & PAGE_MASK;
      ftrap_q <= trap_i & fetch_i;
      dtrap_q <= trap_i & ~fetch_i;
    end
  end

  assign fsr_o        = fsr_q;
  assign far_o        = far_q;
  assign fetch_trap_o = ftrap_q;
  assign data_trap_o  = dtrap_q;
endmodule

// File: rtl/acc_check_unit.sv
module acc_check_unit
  import acc_check_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic            req_fetch_i,
  input  logic            req_super_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [2:0]      pte_perm_i,
  input  logic            pte_mod_i,
  input  logic            nofault_mode_i,
  input  logic            trap_en_i,
  input  logic            fsr_rd_i,
  output logic            fault_o,
  output logic [3:0]      fault_code_o,
  output logic [2:0]      grant_o,
  output logic            fetch_trap_o,
  output logic            data_trap_o,
  output logic [7:0]      fsr_o,
  output logic [VA_W-1:0] far_o
);
  rights_t           rights, grant;
  logic [AIDX_W-1:0] acc_idx;
  fcode_t            code;
  logic              fault, trap;

  acc_rights_dec u_dec (
    .perm_i   (pte_perm_i),
    .super_i  (req_super_i),
    .rights_o (rights)
  );

  acc_fault_eval u_eval (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .fetch_i   (req_fetch_i),
    .super_i   (req_super_i),
    .perm_i    (pte_perm_i),
    .rights_i  (rights),
    .dirty_i   (pte_mod_i),
    .nofault_i (nofault_mode_i),
    .trap_en_i (trap_en_i),
    .acc_idx_o (acc_idx),
    .code_o    (code),
    .fault_o   (fault),
    .trap_o    (trap),
    .grant_o   (grant)
  );

  acc_fault_log #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_log (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_i      (fault),
    .trap_i       (trap),
    .fetch_i      (req_fetch_i),
    .acc_idx_i    (acc_idx),
    .code_i       (code),
    .vaddr_i      (req_vaddr_i),
    .rd_i         (fsr_rd_i),
    .fsr_o        (fsr_o),
    .far_o        (far_o),
    .fetch_trap_o (fetch_trap_o),
    .data_trap_o  (data_trap_o)
  );

  assign fault_o      = fault;
  assign fault_code_o = code;
  assign grant_o      = grant;
endmodule

// File: rtl/acc_check_unit_chk.sv
module acc_check_unit_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PAGE_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_fetch_i,
  input logic            req_super_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic [2:0]      pte_perm_i,
  input logic            pte_mod_i,
  input logic            nofault_mode_i,
  input logic            trap_en_i,
  input logic            fsr_rd_i,
  input logic            fault_o,
  input logic [3:0]      fault_code_o,
  input logic [2:0]      grant_o,
  input logic            fetch_trap_o,
  input logic            data_trap_o,
  input logic [7:0]      fsr_o,
  input logic [VA_W-1:0] far_o
);
  localparam logic [VA_W-1:0] PMASK = {{(VA_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  assert_code_values_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o == 4'd8 || fault_code_o == 4'd12));

  assert_user_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_super_i && !nofault_mode_i && pte_perm_i[2:1] == 2'b11)
      |-> fault_code_o == 4'd12);

  assert_nf_suppress_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nofault_mode_i && !req_super_i) |-> !fault_o);

  assert_no_dirty_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !pte_mod_i && !fault_o) |-> !grant_o[1]);

  assert_bypass_rwx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && (nofault_mode_i || !trap_en_i)) |-> grant_o == 3'b111);

  assert_trap_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_trap_o && data_trap_o));

  assert_fetch_trap_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && req_fetch_i && trap_en_i && !nofault_mode_i) |=> fetch_trap_o);

  assert_status_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fsr_o[1]);

  assert_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fsr_rd_i && fsr_o != 8'd0) |=> fsr_o[0]);

  assert_far_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> far_o == ($past(req_vaddr_i) & PMASK));

  assert_far_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> $stable(far_o));

  assert_read_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsr_rd_i && !fault_o) |=> fsr_o == 8'd0);

  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!fault_o && grant_o == 3'b000));
endmodule

bind acc_check_unit acc_check_unit_chk #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_fetch_i    (req_fetch_i),
  .req_super_i    (req_super_i),
  .req_vaddr_i    (req_vaddr_i),
  .pte_perm_i     (pte_perm_i),
  .pte_mod_i      (pte_mod_i),
  .nofault_mode_i (nofault_mode_i),
  .trap_en_i      (trap_en_i),
  .fsr_rd_i       (fsr_rd_i),
  .fault_o        (fault_o),
  .fault_code_o   (fault_code_o),
  .grant_o        (grant_o),
  .fetch_trap_o   (fetch_trap_o),
  .data_trap_o    (data_trap_o),
  .fsr_o          (fsr_o),
  .far_o          (far_o)
);

// File: tb/acc_check_unit_bench.sv
module acc_check_unit_bench;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PAGE_W = 12;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 0, req_write_i = 0, req_fetch_i = 0, req_super_i = 0;
  logic [VA_W-1:0] req_vaddr_i = '0;
  logic [2:0]      pte_perm_i = '0;
  logic            pte_mod_i = 0, nofault_mode_i = 0, trap_en_i = 0, fsr_rd_i = 0;
  logic            fault_o, fetch_trap_o, data_trap_o;
  logic [3:0]      fault_code_o;
  logic [2:0]      grant_o;
  logic [7:0]      fsr_o;
  logic [VA_W-1:0] far_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_check_unit #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_acc_check_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_fetch_i(req_fetch_i), .req_super_i(req_super_i), .req_vaddr_i(req_vaddr_i),
    .pte_perm_i(pte_perm_i), .pte_mod_i(pte_mod_i), .nofault_mode_i(nofault_mode_i),
    .trap_en_i(trap_en_i), .fsr_rd_i(fsr_rd_i), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .grant_o(grant_o), .fetch_trap_o(fetch_trap_o),
    .data_trap_o(data_trap_o), .fsr_o(fsr_o), .far_o(far_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected fault matrix: 2 bits per permission code, 0 none, 2 -> 8, 3 -> 12
  function automatic logic [3:0] exp_code(input int idx, input int perm);
    logic [15:0] row;
    logic [1:0]  v;
    case (idx)
      0: row = 16'hF200; 1: row = 16'h0200;
      2: row = 16'hF80A; 3: row = 16'h080A;
      4: row = 16'hFA22; 5: row = 16'h2222;
      6: row = 16'hFA2A; default: row = 16'h2A2A;
    endcase
    v = row[2*perm +: 2];
    return (v == 2'd2) ? 4'd8 : (v == 2'd3) ? 4'd12 : 4'd0;
  endfunction

  function automatic logic [2:0] exp_rights(input bit sup, input int perm);
    case (perm)
      0: return 3'd1;
      1: return 3'd3;
      2: return 3'd5;
      3: return 3'd7;
      4: return 3'd4;
      5: return sup ? 3'd3 : 3'd1;
      6: return sup ? 3'd5 : 3'd0;
      default: return sup ? 3'd7 : 3'd0;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]      m_fsr;
    logic [VA_W-1:0] m_far;
    bit              e_ft, e_dt;
    string           fsr_tag;
    int              k;
    m_fsr = '0; m_far = '0; e_ft = 0; e_dt = 0; fsr_tag = "R12"; k = 0;
    #20;
    chk("R12 reset fsr", 32'(fsr_o), 0);
    chk("R12 reset far", far_o, 0);
    chk("R12 reset ftrap", 32'(fetch_trap_o), 0);
    chk("R12 reset dtrap", 32'(data_trap_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v < 2; v++)
      for (int idx = 0; idx < 8; idx++)
        for (int perm = 0; perm < 8; perm++)
          for (int md = 0; md < 2; md++)
            for (int nf = 0; nf < 2; nf++)
              for (int te = 0; te < 2; te++) begin
                bit         user, rd, f, byp;
                logic [3:0] raw, code;
                logic [2:0] g;
                logic [7:0] base;
                string      ctag, gtag;
                @(negedge clk);
                rd = (k % 3 == 0);
                req_valid_i    = v[0];
                req_write_i    = idx[2];
                req_fetch_i    = idx[1];
                req_super_i    = idx[0];
                pte_perm_i     = perm[2:0];
                pte_mod_i      = md[0];
                nofault_mode_i = nf[0];
                trap_en_i      = te[0];
                fsr_rd_i       = rd;
                req_vaddr_i    = 32'h1000_0ABC + 32'(k) * 32'h0004_1203;
                #1;
                // registered results of the previous request
                chk(fsr_tag, 32'(fsr_o), 32'(m_fsr));
                chk("R10 far", far_o, m_far);
                chk("R7 fetch trap", 32'(fetch_trap_o), 32'(e_ft));
                chk("R7 data trap", 32'(data_trap_o), 32'(e_dt));

                user = (idx % 2 == 0);
                raw  = exp_code(idx, perm);
                code = (v == 1 && !(nf == 1 && user)) ? raw : 4'd0;
                f    = (code != 0);
                byp  = (nf == 1) || (te == 0);
                g    = exp_rights(!user, perm);
                if (md == 0) g[1] = 1'b0;
                if (v == 0) g = 3'd0;
                else if (f) g = byp ? 3'd7 : 3'd0;

                if (v == 0) ctag = "R12 code";
                else if (nf == 1 && user && raw != 0) ctag = "R3 code";
                else if (raw == 4'd12) ctag = "R2 code";
                else ctag = "R1 code";
                if (v == 1 && f) gtag = "R6 grant";
                else if (md == 0) gtag = "R5 grant";
                else gtag = "R4 grant";

                chk(ctag, 32'(fault_code_o), 32'(code));
                chk(ctag, 32'(fault_o), 32'(f));
                chk(gtag, 32'(grant_o), 32'(g));

                base = rd ? 8'd0 : m_fsr;
                if (f) begin
                  fsr_tag = (base != 0) ? "R9 fsr" : "R8 fsr";
                  m_fsr = (8'(idx) << 5) | 8'(code) | 8'd2 | ((base != 0) ? 8'd1 : 8'd0);
                  m_far = req_vaddr_i & ~32'hFFF;
                end else begin
                  fsr_tag = rd ? "R11 fsr" : "R12 fsr";
                  m_fsr = base;
                end
                e_ft = f && !byp && (idx / 2) % 2 == 1;
                e_dt = f && !byp && (idx / 2) % 2 == 0;
                k++;
              end

    @(negedge clk);
    req_valid_i = 0;
    fsr_rd_i    = 1;
    #1;
    chk(fsr_tag, 32'(fsr_o), 32'(m_fsr));
    chk("R10 far final", far_o, m_far);
    chk("R7 fetch trap final", 32'(fetch_trap_o), 32'(e_ft));
    chk("R7 data trap final", 32'(data_trap_o), 32'(e_dt));
    @(negedge clk);
    fsr_rd_i = 0;
    #1;
    chk("R11 cleared after read", 32'(fsr_o), 0);
    chk("R7 trap ends", 32'(fetch_trap_o | data_trap_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule